// File: doc/BRIEF.md
# Pointer-Addressed Buffer RAM Access Port

This block gives a host an indirect path into a 2K-byte buffer RAM through a small 8-bit register window. The host never drives a RAM address itself. It sets an 11-bit pointer through two byte registers and then moves data through a single data register. A holding register sits between the data register and the RAM. Reads are fetched into it ahead of time, and host writes are parked in it until the RAM is free. A mode bit makes the pointer step after each data access, so a whole packet can be streamed through one register offset.

A second, internal port shares the same RAM. An arbiter opens one access slot per clock. When the slow mode bit is set, it opens a slot only on every other clock instead. The internal port normally wins a contested slot. A host transfer that has lost once wins the next slot, so it waits no more than one slot. While a host fetch or posted write is outstanding, a busy bit can be read in the status register.

Top module: `ptr_ram_port`

## Requirements
- R1: After reset, every host register offset (0 to 7) reads 0, `int_gnt` is low and `int_rdata` is 0.
- R2: A host write to offset 2 only stages the upper pointer bits (bits 2:0 of the byte; the rest are ignored). The pointer read back at offsets 2 and 3 does not change until offset 3 is written. Offset 2 reads the committed pointer bits 10:8 in bits 2:0, with zeros above them.
- R3: A host write to offset 3 loads the pointer with {staged bits, written byte} and starts a fetch. Busy (offset 0, bit 0) is 1 from the next cycle until the fetch completes. After that, offset 4 returns the RAM byte at the pointer.
- R4: A host write to offset 4 is captured in the holding register, raises busy, and is later written to RAM at the pointer value present at the time of the write.
- R5: With the step bit (offset 1, bit 1) at 1, each data-register read or write advances the pointer by one, and 0x7FF wraps to 0x000. A read also starts a fetch of the byte at the new pointer.
- R6: With the step bit at 0, a data-register read leaves the pointer unchanged and starts no fetch, so busy stays 0 and repeated reads return the same byte.
- R7: With the slow bit (offset 1, bit 0) at 1, arbitration slots occur only on alternate clocks. Two RAM grants never fall on consecutive clocks, and a continuously requesting internal port is granted on exactly 5 of any 10 consecutive clocks.
- R8: `int_gnt` is only high in a slot where `int_req` is high, and the host and the internal port are never served in the same slot. The internal port wins a contested slot unless the pending host transfer lost the previous slot, in which case the host wins. With fast slots and `int_req` held high, busy lasts exactly 2 cycles after a pointer load.
- R9: An internal access takes effect in the cycle `int_gnt` is high. A write stores `int_wdata` at `int_addr`. A read presents the byte at `int_addr` on `int_rdata` from the next cycle on, and this value is held until the next internal read. Both ports see the same RAM contents.
- R10: The register map is: offset 0 status, offset 1 mode, offsets 2 and 3 pointer, offset 4 data. Offsets 5 to 7 read 0, and writes to them change nothing. Offset 1 reads back {zeros, step, slow}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe, one cycle |
| host_rd | input | 1 | Host register read strobe (side effects on offset 4 only) |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register read data for `host_addr`, combinational |
| int_req | input | 1 | Internal port RAM request |
| int_we | input | 1 | Internal port write enable |
| int_addr | input | 11 | Internal port RAM address |
| int_wdata | input | 8 | Internal port write data |
| int_gnt | output | 1 | Internal access performed this cycle |
| int_rdata | output | 8 | Byte from the last internal read |

## Verification
The bench builds the block with its default widths: an 11-bit pointer and an 8-bit register window. This makes the 0x7FF-to-0x000 wrap reachable with a single pointer load, and lets the masking of the upper pointer byte show at real bit positions. Both slot rates are switched at run time through the mode register. This exercises the alternate-clock slot pattern and the one-slot host wait against an internal port that requests without pause. A behavioural model of the slot phase, starvation flag, pointer and RAM contents predicts `int_gnt`, `int_rdata` and the register read data on every clock.

// File: rtl/ptr_ram_pkg.sv
// Shared constants for the pointer-addressed buffer RAM port.
// Assumes a 3-bit host register offset space.
package ptr_ram_pkg;
    localparam int REG_AW = 3;
    localparam logic [REG_AW-1:0] OFF_STATUS = 3'd0;
    localparam logic [REG_AW-1:0] OFF_MODE   = 3'd1;
    localparam logic [REG_AW-1:0] OFF_PTR_HI = 3'd2;
    localparam logic [REG_AW-1:0] OFF_PTR_LO = 3'd3;
    localparam logic [REG_AW-1:0] OFF_DATA   = 3'd4;
endpackage

// File: rtl/ptr_ram_store.sv
// Buffer RAM: synchronous write, combinational read, single shared port.
// Assumes the caller muxes the address and guarantees one access per cycle.
module ptr_ram_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a byte when the granted port writes.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Present the addressed byte without a register stage.
    assign rdata = mem[addr];
endmodule

// File: rtl/ptr_ram_arb.sv
// Slot arbiter between the internal port and the host holding register.
// In slow mode, slots open on alternate clocks. The internal port wins a
// contested slot unless the host lost the previous one.
module ptr_ram_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic slow,
    input  logic int_req,
    input  logic host_pend,
    output logic int_gnt,
    output logic host_go
);
    logic phase_q;
    logic starved_q;
    logic tick;

    // Slot enable: every clock, or only on odd phases when slow.
    assign tick    = ~slow | phase_q;
    assign int_gnt = tick & int_req & ~(host_pend & starved_q);
    assign host_go = tick & host_pend & (~int_req | starved_q);

    // Free-running phase bit for the halved slot rate.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    // Remember that the host lost a slot, so it wins the next one.
    always_ff @(posedge clk) begin
        if (!rst_n)                             starved_q <= 1'b0;
        else if (host_go)                       starved_q <= 1'b0;
        else if (tick & host_pend & int_gnt)    starved_q <= 1'b1;
    end
endmodule

// File: rtl/ptr_ram_host.sv
// Host register window: mode bits, staged/committed pointer, holding
// register and the pending-transfer state. Assumes the host waits for
// busy to clear before its next data access.
module ptr_ram_host
    import ptr_ram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              host_go,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              pend,
    output logic              pend_we,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] hold,
    output logic [ADDR_W-1:0] ptr,
    output logic              step_en,
    output logic              slow
);
    localparam int HI_W = ADDR_W - DATA_W;
    localparam logic [ADDR_W-1:0] ONE = 1;

    logic [HI_W-1:0]   stage_q;
    logic [ADDR_W-1:0] ptr_q, acc_q;
    logic [DATA_W-1:0] hold_q;
    logic              pend_q, we_q, step_q, slow_q;
    logic              wr_mode, wr_hi, wr_lo, wr_data, rd_step;

    assign wr_mode = host_wr && host_addr == OFF_MODE;
    assign wr_hi   = host_wr && host_addr == OFF_PTR_HI;
    assign wr_lo   = host_wr && host_addr == OFF_PTR_LO;
    assign wr_data = host_wr && host_addr == OFF_DATA;
    assign rd_step = host_rd && !host_wr && host_addr == OFF_DATA && step_q;

    // Mode bits and the staged upper pointer bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= 1'b0;
            slow_q  <= 1'b0;
            stage_q <= '0;
        end else begin
            if (wr_mode) {step_q, slow_q} <= host_wdata[1:0];
            if (wr_hi)   stage_q <= host_wdata[HI_W-1:0];
        end
    end

    // Pointer, access address, holding register and pending transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            acc_q  <= '0;
            hold_q <= '0;
            pend_q <= 1'b0;
            we_q   <= 1'b0;
        end else begin
            if (host_go) begin
                pend_q <= 1'b0;
                if (!we_q) hold_q <= ram_rdata;
            end
            if (wr_lo) begin
                ptr_q  <= {stage_q, host_wdata};
                acc_q  <= {stage_q, host_wdata};
                pend_q <= 1'b1;
                we_q   <= 1'b0;
            end
            if (wr_data) begin
                hold_q <= host_wdata;
                acc_q  <= ptr_q;
                pend_q <= 1'b1;
                we_q   <= 1'b1;
                if (step_q) ptr_q <= ptr_q + ONE;
            end
            if (rd_step) begin
                ptr_q  <= ptr_q + ONE;
                acc_q  <= ptr_q + ONE;
                pend_q <= 1'b1;
                we_q   <= 1'b0;
            end
        end
    end

    // Register read-back multiplexer.
    always_comb begin
        unique case (host_addr)
            OFF_STATUS: host_rdata = {{(DATA_W-1){1'b0}}, pend_q};
            OFF_MODE:   host_rdata = {{(DATA_W-2){1'b0}}, step_q, slow_q};
            OFF_PTR_HI: host_rdata = {{(DATA_W-HI_W){1'b0}}, ptr_q[ADDR_W-1:DATA_W]};
            OFF_PTR_LO: host_rdata = ptr_q[DATA_W-1:0];
            OFF_DATA:   host_rdata = hold_q;
            default:    host_rdata = '0;
        endcase
    end

    assign pend     = pend_q;
    assign pend_we  = we_q;
    assign acc_addr = acc_q;
    assign hold     = hold_q;
    assign ptr      = ptr_q;
    assign step_en  = step_q;
    assign slow     = slow_q;
endmodule

// File: rtl/ptr_ram_port.sv
// Top: host pointer window plus internal port sharing one buffer RAM.
// Assumes ADDR_W > DATA_W and ADDR_W <= 2*DATA_W.
module ptr_ram_port
    import ptr_ram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              int_req,
    input  logic              int_we,
    input  logic [ADDR_W-1:0] int_addr,
    input  logic [DATA_W-1:0] int_wdata,
    output logic              int_gnt,
    output logic [DATA_W-1:0] int_rdata
);
    logic              pend_w, pend_we_w, step_w, slow_w, host_go_w, gnt_w;
    logic [ADDR_W-1:0] acc_w, ptr_w, ram_addr;
    logic [DATA_W-1:0] hold_w, ram_rdata, ram_wdata, int_rdata_q;
    logic              ram_we;

    ptr_ram_host #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_host (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_go(host_go_w), .ram_rdata(ram_rdata), .pend(pend_w),
        .pend_we(pend_we_w), .acc_addr(acc_w), .hold(hold_w), .ptr(ptr_w),
        .step_en(step_w), .slow(slow_w)
    );

    ptr_ram_arb u_arb (
        .clk(clk), .rst_n(rst_n), .slow(slow_w), .int_req(int_req),
        .host_pend(pend_w), .int_gnt(gnt_w), .host_go(host_go_w)
    );

    // Route the granted port onto the single RAM port.
    assign ram_addr  = gnt_w ? int_addr  : acc_w;
    assign ram_wdata = gnt_w ? int_wdata : hold_w;
    assign ram_we    = gnt_w ? int_we    : (host_go_w & pend_we_w);

    ptr_ram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata),
        .rdata(ram_rdata)
    );

    // Capture the byte of a granted internal read.
    always_ff @(posedge clk) begin
        if (!rst_n)                 int_rdata_q <= '0;
        else if (gnt_w && !int_we)  int_rdata_q <= ram_rdata;
    end

    assign int_gnt   = gnt_w;
    assign int_rdata = int_rdata_q;
endmodule

// File: rtl/ptr_ram_port_chk.sv
// Protocol checker for ptr_ram_port, attached with bind.
module ptr_ram_port_chk
    import ptr_ram_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic [REG_AW-1:0] host_addr,
    input logic              busy,
    input logic [ADDR_W-1:0] ptr,
    input logic              step_en,
    input logic              slow,
    input logic              int_req,
    input logic              int_gnt,
    input logic              host_go
);
    // R8
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_gnt |-> int_req);
    // R8
    one_port_per_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_gnt && host_go));
    // R3
    lo_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFF_PTR_LO) |=> busy);
    // R2
    hi_stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFF_PTR_HI) |=> $stable(ptr));
    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && host_rd && !host_wr && host_addr == OFF_DATA && ptr == '1)
        |=> ptr == '0);
    // R6
    no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && host_rd && !host_wr && host_addr == OFF_DATA) |=> $stable(ptr));
    // R7
    slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slow && $past(slow) && $past(int_gnt || host_go)) |-> !(int_gnt || host_go));
endmodule

bind ptr_ram_port ptr_ram_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .busy(pend_w), .ptr(ptr_w), .step_en(step_w),
    .slow(slow_w), .int_req(int_req), .int_gnt(int_gnt), .host_go(host_go_w)
);

// File: tb/sim_ptr_ram_port.sv
module sim_ptr_ram_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        int_req = 1'b0, int_we = 1'b0;
    logic [10:0] int_addr = '0;
    logic [7:0]  int_wdata = '0;
    logic        int_gnt;
    logic [7:0]  int_rdata;

    int n_chk = 0, n_fail = 0;
    int m_mem [2048];
    int m_hold, m_irdata, m_ptr, m_stage, m_acc;
    bit m_pend, m_we, m_step, m_slow, m_phase, m_starved;
    int ref_pkt [16];

    always #5 clk = ~clk;

    ptr_ram_port u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .int_req(int_req), .int_we(int_we), .int_addr(int_addr),
        .int_wdata(int_wdata), .int_gnt(int_gnt), .int_rdata(int_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        bit tick, go, ig;
        if (!rst_n) begin
            m_hold = 0; m_irdata = 0; m_ptr = 0; m_stage = 0; m_acc = 0;
            m_pend = 0; m_we = 0; m_step = 0; m_slow = 0; m_phase = 0; m_starved = 0;
        end else begin
            tick = !m_slow || m_phase;
            go   = tick && m_pend && (!int_req || m_starved);
            ig   = tick && int_req && !(m_pend && m_starved);
            if (ig) begin
                if (int_we) m_mem[int_addr] = int_wdata;
                else        m_irdata = m_mem[int_addr];
            end
            if (go) begin
                if (m_we) m_mem[m_acc] = m_hold;
                else      m_hold = m_mem[m_acc];
                m_pend = 0; m_starved = 0;
            end else if (tick && m_pend && ig) m_starved = 1;
            if (host_wr) begin
                case (host_addr)
                    3'd1: begin m_step = host_wdata[1]; m_slow = host_wdata[0]; end
                    3'd2: m_stage = host_wdata & 7;
                    3'd3: begin m_ptr = m_stage * 256 + host_wdata; m_acc = m_ptr;
                                m_pend = 1; m_we = 0; end
                    3'd4: begin m_hold = host_wdata; m_acc = m_ptr; m_pend = 1; m_we = 1;
                                if (m_step) m_ptr = (m_ptr + 1) & 11'h7FF; end
                    default: ;
                endcase
            end else if (host_rd && host_addr == 3'd4 && m_step) begin
                m_ptr = (m_ptr + 1) & 11'h7FF; m_acc = m_ptr; m_pend = 1; m_we = 0;
            end
            m_phase = !m_phase;
        end
    end

    // Per-clock comparison just before each rising edge.
    initial begin
        forever begin
            @(negedge clk); #4;
            if (rst_n) begin
                int exp_rd;
                bit  tick, ig;
                tick = !m_slow || m_phase;
                ig   = tick && int_req && !(m_pend && m_starved);
                chk(int_gnt == ig, "R8 int_gnt", int_gnt, ig);
                case (host_addr)
                    3'd0: exp_rd = m_pend;
                    3'd1: exp_rd = m_step * 2 + m_slow;
                    3'd2: exp_rd = m_ptr >> 8;
                    3'd3: exp_rd = m_ptr & 255;
                    3'd4: exp_rd = m_hold;
                    default: exp_rd = 0;
                endcase
                if (exp_rd >= 0) chk(host_rdata == exp_rd, "R10 host_rdata", host_rdata, exp_rd);
                if (m_irdata >= 0) chk(int_rdata == m_irdata, "R9 int_rdata", int_rdata, m_irdata);
            end
        end
    end

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); host_rd = 1; host_addr = a;
        #4 d = host_rdata;
        @(negedge clk); host_rd = 0;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 20; i++) begin
            reg_rd(3'd0, v);
            if (v[0] == 1'b0) break;
        end
    endtask

    task automatic ptr_load(input int a);
        reg_wr(3'd2, 8'(a >> 8));
        reg_wr(3'd3, 8'(a & 255));
        wait_idle();
    endtask

    task automatic int_op(input bit we, input int a, input int d, input int exp);
        bit g;
        @(negedge clk); int_req = 1; int_we = we; int_addr = 11'(a); int_wdata = 8'(d);
        for (int i = 0; i < 10; i++) begin
            #4 g = int_gnt;
            @(negedge clk);
            if (g) break;
        end
        int_req = 0; int_we = 0;
        if (!we) begin
            #4 chk(int_rdata == exp, "R9 internal read", int_rdata, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [7:0] v, v2;
        int g, busy_n;
        for (int i = 0; i < 2048; i++) m_mem[i] = -1;
        for (int i = 0; i < 16; i++) ref_pkt[i] = (i * 37 + 5) & 255;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state of every offset
        for (int a = 0; a < 8; a++) begin
            reg_rd(3'(a), v);
            chk(v == 0, "R1 reset register", v, 0);
        end
        chk(int_gnt == 0, "R1 reset int_gnt", int_gnt, 0);

        // R10: unused offsets ignore writes; mode read-back
        reg_wr(3'd5, 8'hFF);
        reg_rd(3'd5, v);
        chk(v == 0, "R10 unused offset", v, 0);
        reg_wr(3'd1, 8'hFE);
        reg_rd(3'd1, v);
        chk(v == 8'h02, "R10 mode readback", v, 2);

        // R2: high byte only stages, upper bits masked
        reg_wr(3'd2, 8'hFF);
        reg_rd(3'd2, v);
        chk(v == 0, "R2 staged high not visible", v, 0);
        reg_wr(3'd3, 8'h10);
        wait_idle();
        reg_rd(3'd2, v);
        reg_rd(3'd3, v2);
        chk(v == 8'h07 && v2 == 8'h10, "R2 committed pointer", {v, v2}, 16'h0710);

        // R4/R5: stream a packet in with stepping across a 256-byte boundary
        ptr_load(11'h0F8);
        for (int i = 0; i < 16; i++) begin
            reg_wr(3'd4, 8'(ref_pkt[i]));
            wait_idle();
        end
        reg_rd(3'd2, v);
        reg_rd(3'd3, v2);
        chk({v, v2} == 16'h0108, "R5 pointer after stream", {v, v2}, 16'h0108);

        // R3/R5: stream it back out
        ptr_load(11'h0F8);
        for (int i = 0; i < 16; i++) begin
            reg_rd(3'd4, v);
            chk(v == ref_pkt[i], "R4 packet byte", v, ref_pkt[i]);
            wait_idle();
        end

        // R6: no stepping, no fetch
        reg_wr(3'd1, 8'h00);
        ptr_load(11'h0F9);
        reg_rd(3'd4, v);
        reg_rd(3'd0, v2);
        chk(v2 == 0, "R6 no busy after read", v2, 0);
        reg_rd(3'd4, v2);
        chk(v == v2 && v == ref_pkt[1], "R6 repeat read", v2, ref_pkt[1]);
        reg_rd(3'd3, v);
        chk(v == 8'hF9, "R6 pointer unchanged", v, 8'hF9);

        // R5: wrap from top address to zero
        reg_wr(3'd1, 8'h02);
        ptr_load(11'h7FF);
        reg_wr(3'd4, 8'hA5);
        wait_idle();
        reg_rd(3'd2, v);
        reg_rd(3'd3, v2);
        chk({v, v2} == 16'h0000, "R5 wrap on write", {v, v2}, 0);
        reg_wr(3'd4, 8'h5A);
        wait_idle();
        ptr_load(11'h7FF);
        reg_rd(3'd4, v);
        chk(v == 8'hA5, "R5 byte at top", v, 8'hA5);
        wait_idle();
        reg_rd(3'd4, v);
        chk(v == 8'h5A, "R5 byte after wrap", v, 8'h5A);
        wait_idle();

        // R9: internal write and read share the RAM with the host
        int_op(1, 11'h300, 8'h3C, 0);
        int_op(0, 11'h300, 0, 8'h3C);
        int_op(0, 11'h0FA, 0, ref_pkt[2]);
        ptr_load(11'h300);
        reg_rd(3'd4, v);
        chk(v == 8'h3C, "R9 host sees internal write", v, 8'h3C);
        wait_idle();

        // R8: internal port requesting without pause; host waits one slot
        reg_wr(3'd2, 8'h00);
        @(negedge clk); int_req = 1; int_we = 0; int_addr = 11'h0F8;
        reg_wr(3'd3, 8'hF8);
        host_addr = 3'd0;
        busy_n = 0;
        for (int i = 0; i < 10; i++) begin
            #4 if (host_rdata[0]) busy_n++;
            @(negedge clk);
        end
        int_req = 0;
        chk(busy_n == 2, "R8 host wait bound", busy_n, 2);
        reg_rd(3'd4, v);
        chk(v == ref_pkt[0], "R8 fetched byte", v, ref_pkt[0]);
        wait_idle();

        // R7: slow slots
        reg_wr(3'd1, 8'h03);
        @(negedge clk); int_req = 1; int_we = 0; int_addr = 11'h0FB;
        g = 0;
        for (int i = 0; i < 10; i++) begin
            #4 if (int_gnt) g++;
            @(negedge clk);
        end
        int_req = 0;
        chk(g == 5, "R7 grants in 10 slow clocks", g, 5);
        ptr_load(11'h0F8);
        for (int i = 0; i < 4; i++) begin
            reg_rd(3'd4, v);
            chk(v == ref_pkt[i], "R7 slow stream byte", v, ref_pkt[i]);
            wait_idle();
        end

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule